// File: doc/BRIEF.md
# Accumulator Adder and Rotate Datapath

This block is the arithmetic slice of a 12-bit accumulator machine. Each cycle it forms two operands, adds them in a ripple-carry adder, builds a link bit from a selected link source and the adder carry, and passes the 13-bit value of link and sum through a circular rotate stage. The 13-bit result is always visible on an output. When the write enable is high, the result is loaded into the link and accumulator registers at the next rising clock edge.

The first operand comes from the shared operand bus. It can be taken as is, forced to zero, ANDed with the accumulator, or ORed with the accumulator. The second operand is the accumulator, its complement, all zeros or all ones. Together these give clear, load, complement, increment and the logic operations without a separate logic unit. Instruction decoding, memory and other registers are outside the block. Plain select inputs stand in for them.

Top module: `acc_alu_top`

## Requirements
- R1: The adder sum is (operand A + operand B) mod 4096. The carry-out is 1 exactly when the true sum is 4096 or more. With operand A zero and operand B all zeros, the low 12 bits of the result are 0 whenever no single rotate is selected.
- R2: The operand A code `opa_sel` selects: 0 the bus, 1 zero, 2 the bus AND the accumulator, 3 the bus OR the accumulator.
- R3: The operand B code `opb_sel` selects: 0 the accumulator, 1 its bitwise complement, 2 octal 0000, 3 octal 7777.
- R4: The link code `lnk_sel` selects: 0 the link, 1 its complement, 2 constant 0, 3 constant 1. The selected bit XOR the adder carry-out becomes bit 12 of the rotate input. Bits 11..0 of the rotate input are the sum.
- R5: With only `rot_l1` high, result bit i equals rotate input bit i-1, and result bit 0 equals input bit 12.
- R6: With only `rot_l2` high, the result is the 13-bit rotate input rotated left circularly by two places.
- R7: With only `rot_r1` high, the input is rotated right by one place circularly, so bit 12 receives bit 0. With only `rot_r2` high, it is rotated right by two places.
- R8: When no rotate control is high, or more than one is high, the result equals the rotate input unchanged.
- R9: When `wr_en` is high at a rising edge, result bit 12 loads the link and bits 11..0 load the accumulator. When `wr_en` is low, both registers keep their values.
- R10: A synchronous, active-high `rst` clears the accumulator and the link to zero. Reset takes priority over `wr_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 12 | Shared operand bus value |
| opa_sel | input | 2 | Operand A select code |
| opb_sel | input | 2 | Operand B select code |
| lnk_sel | input | 2 | Link source select code |
| rot_l1 | input | 1 | Rotate left by one |
| rot_l2 | input | 1 | Rotate left by two |
| rot_r1 | input | 1 | Rotate right by one |
| rot_r2 | input | 1 | Rotate right by two |
| wr_en | input | 1 | Load result into link and accumulator |
| result | output | 13 | Link (bit 12) and sum after rotation |
| acc_q | output | 12 | Accumulator register |
| link_q | output | 1 | Link register |

## Verification
The registers are the only state. A wrong accumulator or link value shows up on `acc_q` and `link_q` in the cycle after the bad load. It also changes `result` at once whenever a select code routes the accumulator or link into the datapath. The bench keeps its own accumulator and link and compares them against the ports after every edge. It compares the combinational result within the same cycle. A corrupted register is therefore caught one clock after it goes wrong, and a wrong datapath mapping is caught in the cycle it is exercised. Every combination of operand, link and rotate code is driven with random operands.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    typedef enum logic [1:0] {
        OPA_BUS  = 2'd0,
        OPA_ZERO = 2'd1,
        OPA_AND  = 2'd2,
        OPA_OR   = 2'd3
    } opa_sel_e;

    typedef enum logic [1:0] {
        OPB_ACC  = 2'd0,
        OPB_NACC = 2'd1,
        OPB_ZERO = 2'd2,
        OPB_ONES = 2'd3
    } opb_sel_e;

    typedef enum logic [1:0] {
        LNK_KEEP = 2'd0,
        LNK_INV  = 2'd1,
        LNK_CLR  = 2'd2,
        LNK_SET  = 2'd3
    } lnk_sel_e;

    typedef enum logic [2:0] {
        ROT_NONE = 3'd0,
        ROT_L1   = 3'd1,
        ROT_L2   = 3'd2,
        ROT_R1   = 3'd3,
        ROT_R2   = 3'd4
    } rot_op_e;

    typedef struct packed {
        logic l1;
        logic l2;
        logic r1;
        logic r2;
    } rot_ctl_t;

    // Exactly one active control selects a rotation; anything else passes through.
    function automatic rot_op_e rot_decode(input rot_ctl_t c);
        rot_op_e op;
        case (c)
            4'b1000: op = ROT_L1;
            4'b0100: op = ROT_L2;
            4'b0010: op = ROT_R1;
            4'b0001: op = ROT_R2;
            default: op = ROT_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/acc_opa_mux.sv
`timescale 1ns/1ps
module acc_opa_mux
    import acc_alu_pkg::*;
#(
    parameter int W = 12
) (
    input  opa_sel_e       sel,
    input  logic [W-1:0]   bus_val,
    input  logic [W-1:0]   acc_val,
    output logic [W-1:0]   opa
);
    always_comb begin
        case (sel)
            OPA_BUS:  opa = bus_val;
            OPA_ZERO: opa = '0;
            OPA_AND:  opa = bus_val & acc_val;
            OPA_OR:   opa = bus_val | acc_val;
            default:  opa = '0;
        endcase
    end
endmodule

// File: rtl/acc_opb_mux.sv
`timescale 1ns/1ps
module acc_opb_mux
    import acc_alu_pkg::*;
#(
    parameter int W = 12
) (
    input  opb_sel_e       sel,
    input  logic [W-1:0]   acc_val,
    output logic [W-1:0]   opb
);
    always_comb begin
        case (sel)
            OPB_ACC:  opb = acc_val;
            OPB_NACC: opb = ~acc_val;
            OPB_ZERO: opb = '0;
            OPB_ONES: opb = '1;
            default:  opb = '0;
        endcase
    end
endmodule

// File: rtl/acc_ripple_add.sv
`timescale 1ns/1ps
module acc_ripple_add #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic p;
        assign p          = a[i] ^ b[i];
        assign sum[i]     = p ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (p & chain[i]);
    end

    assign cout = chain[W];
endmodule

// File: rtl/acc_link_unit.sv
`timescale 1ns/1ps
module acc_link_unit
    import acc_alu_pkg::*;
(
    input  lnk_sel_e sel,
    input  logic     link_val,
    input  logic     carry,
    output logic     link_out
);
    logic chosen;

    always_comb begin
        case (sel)
            LNK_KEEP: chosen = link_val;
            LNK_INV:  chosen = ~link_val;
            LNK_CLR:  chosen = 1'b0;
            LNK_SET:  chosen = 1'b1;
            default:  chosen = 1'b0;
        endcase
    end

    assign link_out = chosen ^ carry;
endmodule

// File: rtl/acc_rotator.sv
`timescale 1ns/1ps
module acc_rotator
    import acc_alu_pkg::*;
#(
    parameter int RW = 13
) (
    input  rot_op_e         op,
    input  logic [RW-1:0]   din,
    output logic [RW-1:0]   dout
);
    for (genvar i = 0; i < RW; i++) begin : g_bit
        localparam int SRC_L1 = (i + RW - 1) % RW;
        localparam int SRC_L2 = (i + RW - 2) % RW;
        localparam int SRC_R1 = (i + 1) % RW;
        localparam int SRC_R2 = (i + 2) % RW;

        always_comb begin
            case (op)
                ROT_L1:  dout[i] = din[SRC_L1];
                ROT_L2:  dout[i] = din[SRC_L2];
                ROT_R1:  dout[i] = din[SRC_R1];
                ROT_R2:  dout[i] = din[SRC_R2];
                default: dout[i] = din[i];
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_top.sv
`timescale 1ns/1ps
module acc_alu_top
    import acc_alu_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_in,
    input  logic [1:0]    opa_sel,
    input  logic [1:0]    opb_sel,
    input  logic [1:0]    lnk_sel,
    input  logic          rot_l1,
    input  logic          rot_l2,
    input  logic          rot_r1,
    input  logic          rot_r2,
    input  logic          wr_en,
    output logic [DW:0]   result,
    output logic [DW-1:0] acc_q,
    output logic          link_q
);
    localparam int RW = DW + 1;

    logic [DW-1:0] opa, opb, sum;
    logic          carry, link_bit;
    logic [RW-1:0] rot_src;
    rot_ctl_t      rot_ctl;
    rot_op_e       rot_op;

    acc_opa_mux #(.W(DW)) u_opa (
        .sel     (opa_sel_e'(opa_sel)),
        .bus_val (bus_in),
        .acc_val (acc_q),
        .opa     (opa)
    );

    acc_opb_mux #(.W(DW)) u_opb (
        .sel     (opb_sel_e'(opb_sel)),
        .acc_val (acc_q),
        .opb     (opb)
    );

    acc_ripple_add #(.W(DW)) u_add (
        .a    (opa),
        .b    (opb),
        .sum  (sum),
        .cout (carry)
    );

    acc_link_unit u_lnk (
        .sel      (lnk_sel_e'(lnk_sel)),
        .link_val (link_q),
        .carry    (carry),
        .link_out (link_bit)
    );

    assign rot_src = {link_bit, sum};
    assign rot_ctl = '{l1: rot_l1, l2: rot_l2, r1: rot_r1, r2: rot_r2};
    assign rot_op  = rot_decode(rot_ctl);

    acc_rotator #(.RW(RW)) u_rot (
        .op   (rot_op),
        .din  (rot_src),
        .dout (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            link_q <= 1'b0;
        end else if (wr_en) begin
            acc_q  <= result[DW-1:0];
            link_q <= result[DW];
        end
    end
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rot_l1,
    input logic          rot_l2,
    input logic          rot_r1,
    input logic          rot_r2,
    input logic [1:0]    opa_sel,
    input logic [1:0]    opb_sel,
    input logic [DW:0]   rot_src,
    input logic [DW:0]   result,
    input logic [DW-1:0] acc_q,
    input logic          link_q
);
    localparam int RW = DW + 1;

    logic [3:0] rots;
    assign rots = {rot_l1, rot_l2, rot_r1, rot_r2};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && link_q == 1'b0)); // R10

    AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ({link_q, acc_q} == $past(result))); // R9

    AST_HOLD_STATE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable({link_q, acc_q})); // R9

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        ($countones(rots) != 1) |-> (result == rot_src)); // R8

    AST_LEFT_ONE: assert property (@(posedge clk) disable iff (rst)
        (rots == 4'b1000) |-> (result == {rot_src[RW-2:0], rot_src[RW-1]})); // R5

    AST_RIGHT_TWO: assert property (@(posedge clk) disable iff (rst)
        (rots == 4'b0001) |-> (result == {rot_src[1:0], rot_src[RW-1:2]})); // R7

    AST_ZERO_SUM: assert property (@(posedge clk) disable iff (rst)
        (opa_sel == 2'd1 && opb_sel == 2'd2 && $countones(rots) != 1)
        |-> (result[DW-1:0] == '0)); // R1
endmodule

bind acc_alu_top acc_alu_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rot_l1  (rot_l1),
    .rot_l2  (rot_l2),
    .rot_r1  (rot_r1),
    .rot_r2  (rot_r2),
    .opa_sel (opa_sel),
    .opb_sel (opb_sel),
    .rot_src (rot_src),
    .result  (result),
    .acc_q   (acc_q),
    .link_q  (link_q)
);

// File: tb/sim_acc_alu_top.sv
`timescale 1ns/1ps
module sim_acc_alu_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_in = '0;
    logic [1:0]  opa_sel = '0, opb_sel = '0, lnk_sel = '0;
    logic        rot_l1 = 0, rot_l2 = 0, rot_r1 = 0, rot_r2 = 0;
    logic        wr_en = 1'b0;
    logic [12:0] result;
    logic [11:0] acc_q;
    logic        link_q;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    int m_acc  = 0;
    int m_link = 0;

    always #4 clk = ~clk;

    acc_alu_top u0 (
        .clk(clk), .rst(rst), .bus_in(bus_in),
        .opa_sel(opa_sel), .opb_sel(opb_sel), .lnk_sel(lnk_sel),
        .rot_l1(rot_l1), .rot_l2(rot_l2), .rot_r1(rot_r1), .rot_r2(rot_r2),
        .wr_en(wr_en), .result(result), .acc_q(acc_q), .link_q(link_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%o expected=%o", req, act, exp);
        end
    endtask

    // Behavioural reference; rot bits: [3]=left1 [2]=left2 [1]=right1 [0]=right2
    function automatic int model(input int b, input int oa, input int ob, input int ls,
                                 input int rot);
        int a, bb, s, c, l, v;
        case (oa)
            0: a = b;
            1: a = 0;
            2: a = b & m_acc;
            default: a = b | m_acc;
        endcase
        case (ob)
            0: bb = m_acc;
            1: bb = 4095 - m_acc;
            2: bb = 0;
            default: bb = 4095;
        endcase
        s = a + bb;
        c = (s >= 4096) ? 1 : 0;
        case (ls)
            0: l = m_link;
            1: l = 1 - m_link;
            2: l = 0;
            default: l = 1;
        endcase
        v = ((l ^ c) * 4096) + (s % 4096);
        case (rot)
            8: v = ((v * 2) + (v / 4096)) % 8192;
            4: v = ((v * 4) + (v / 2048)) % 8192;
            2: v = (v / 2) + ((v % 2) * 4096);
            1: v = (v / 4) + ((v % 4) * 2048);
            default: ;
        endcase
        return v;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input int b, input int oa, input int ob, input int ls,
                        input int rot, input bit we);
        int exp;
        string tag;
        bus_in = b[11:0]; opa_sel = oa[1:0]; opb_sel = ob[1:0]; lnk_sel = ls[1:0];
        {rot_l1, rot_l2, rot_r1, rot_r2} = rot[3:0];
        wr_en = we;
        #1;
        exp = model(b, oa, ob, ls, rot);
        case (rot)
            8: tag = "R1/R2/R3/R4/R5 left1";
            4: tag = "R1/R2/R3/R4/R6 left2";
            2: tag = "R1/R2/R3/R4/R7 right1";
            1: tag = "R1/R2/R3/R4/R7 right2";
            default: tag = "R1/R2/R3/R4/R8 pass";
        endcase
        check(int'(result) == exp, tag, int'(result), exp);
        @(posedge clk);
        if (we) begin
            m_acc  = exp % 4096;
            m_link = exp / 4096;
        end
        @(negedge clk);
        check(int'({link_q, acc_q}) == m_link * 4096 + m_acc, "R9 registers",
              int'({link_q, acc_q}), m_link * 4096 + m_acc);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(acc_q == 0 && link_q == 0, "R10 reset state", int'({link_q, acc_q}), 0);
        rst = 1'b0;

        // R9: load octal 7777 with link set, then hold with wr_en low
        step(12'o7777, 0, 2, 3, 0, 1);
        step(12'o1234, 0, 2, 2, 0, 0);
        // R1/R4: 0001 + 7777 wraps to 0000, carry flips the kept link 1 to 0
        step(12'o0001, 0, 0, 0, 0, 1);
        // R1: zero plus zero with a non-single rotate set
        step(12'o5555, 1, 2, 2, 4'b1100, 0);
        // R5/R7: single bit at the wrap positions
        step(12'o0000, 1, 3, 2, 8, 0);
        step(12'o0001, 0, 2, 2, 2, 0);
        step(12'o0001, 0, 2, 2, 1, 0);

        // every select and rotate combination with random operands
        for (int oa = 0; oa < 4; oa++)
            for (int ob = 0; ob < 4; ob++)
                for (int ls = 0; ls < 4; ls++)
                    for (int r = 0; r < 16; r++)
                        step(int'($urandom_range(0, 4095)), oa, ob, ls, r,
                             1'($urandom_range(0, 1)));

        for (int n = 0; n < 3000; n++)
            step(int'($urandom_range(0, 4095)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                 int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));

        // R10: reset from a loaded state, with wr_en held high
        step(12'o7777, 0, 2, 3, 0, 1);
        rst = 1'b1;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(acc_q == 0 && link_q == 0, "R10 reset over wr_en", int'({link_q, acc_q}), 0);
        rst = 1'b0;
        wr_en = 1'b0;

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule